// File: doc/BRIEF.md
# Multi-Bank IN Endpoint Transmit Buffer

This block holds the outgoing packet memory of a single device-to-host endpoint. The memory is divided into one to `NBANK` equal banks, and the banks are used in a ring. The CPU pushes packet bytes one at a time into the bank that is currently open for writing. A bank is handed to the transmitter in one of two ways:

- The CPU issues a set-only "transmit ready" strobe.
- When auto-validation is enabled, the bank is handed over as soon as its final byte is written. Writing then carries on into the following bank.

A strobe on a bank that holds no data queues a zero-length packet.

The transmitter side sees the oldest ready bank: its presence, its byte length and a random-access read port into its bytes. After sending the bank, the transmitter pulses an acknowledge, which releases the bank. The CPU sees three things: a count of occupied banks, the ready flag of the bank it is about to fill, and two level interrupts with individual enables. One interrupt reports that the write bank is free; the other reports that every bank is free. Auto-validation is meant for bulk and interrupt endpoints. Software keeps it off for isochronous traffic.

Top module: `tbc_in_endpoint`

## Requirements
- R1: After synchronous reset, `busy_cnt` is 0, `tx_valid` is 0, `cpu_txrdy` is 0, and both interrupts follow their enables (all banks free).
- R2: In manual mode, N accepted byte writes followed by a `cpu_set_txrdy` pulse make that bank ready with `tx_len` = N. The bytes read back at `tx_rd_addr` 0..N-1 in the order they were written.
- R3: A `cpu_set_txrdy` pulse on an open bank with no bytes written queues a ready bank with `tx_len` = 0.
- R4: While the open write bank is ready, byte writes to it are ignored. They change neither the stored bytes nor the fill position.
- R5: With `cfg_auto_val` = 1, writing byte index `BANK_BYTES-1` makes the bank ready with `tx_len` = `BANK_BYTES` in the same cycle. The next byte goes to index 0 of the following bank.
- R6: In auto mode, a partly filled bank stays not-ready until `cpu_set_txrdy` is pulsed. The pulse then makes it ready with its partial length.
- R7: Banks reach the transmitter strictly in the order they were made ready. Write and read positions wrap modulo the effective bank count, where `cfg_nbanks` values of 0 and 1 both mean one bank.
- R8: A `tx_ack` pulse while `tx_valid` is 1 frees the oldest ready bank. A `tx_ack` with no ready bank has no effect.
- R9: `busy_cnt` equals the number of ready, unacknowledged banks and never exceeds the effective bank count.
- R10: `irq_bank_free` is `irq_free_en` AND (open write bank not ready). `irq_all_free` is `irq_all_en` AND (`busy_cnt` = 0).
- R11: A `cpu_set_txrdy` pulse while the open write bank is already ready is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nbanks | input | CNT_W | Banks in use (0 treated as 1, capped at NBANK) |
| cfg_auto_val | input | 1 | Auto-validate on last byte of a bank |
| cpu_wr_en | input | 1 | Byte write strobe into the open bank |
| cpu_wr_data | input | 8 | Byte to write |
| cpu_set_txrdy | input | 1 | Set-only transmit-ready strobe for the open bank |
| cpu_txrdy | output | 1 | Ready flag of the open write bank |
| busy_cnt | output | CNT_W | Number of ready banks |
| irq_free_en | input | 1 | Enable for the bank-free interrupt |
| irq_all_en | input | 1 | Enable for the all-free interrupt |
| irq_bank_free | output | 1 | Open write bank is free |
| irq_all_free | output | 1 | Every bank is free |
| tx_valid | output | 1 | Oldest ready bank present |
| tx_len | output | LEN_W | Byte length of the oldest ready bank |
| tx_rd_addr | input | OFF_W | Byte index to read in the oldest ready bank |
| tx_rd_data | output | 8 | Byte at `tx_rd_addr` |
| tx_ack | input | 1 | Transmit finished; frees the oldest ready bank |

## Verification
The bench fills every bank in one run, starting from a write position that is not zero, and then drains the banks. A design with a broken wrap or with write and read pointers that disagree would return the bytes in the wrong order or would never finish draining. With a single bank in use, the bench fills the bank and then sends a byte write and a ready strobe while it is occupied. A design that let either of these through would corrupt the stored byte or count a second bank. The bench then checks that a strobe after the release yields a zero-length packet, which proves the ignored write did not move the fill position. In auto mode, the bench crosses a bank boundary in the middle of a stream and leaves a partial tail. A design that validated late, or that validated a partial bank without the strobe, shows the wrong count or the wrong length. The bench also sends an acknowledge while nothing is ready, which must not wrap the count below zero.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        CM_NONE   = 2'd0,
        CM_MANUAL = 2'd1,
        CM_AUTO   = 2'd2
    } commit_e;

    // Next ring position, wrapping at n entries.
    function automatic int unsigned ring_next(int unsigned p, int unsigned n);
        return (p + 1 >= n) ? 0 : p + 1;
    endfunction

    // Bank count actually in use for a configured value.
    function automatic int unsigned eff_banks(int unsigned cfg, int unsigned nmax);
        if (cfg == 0) return 1;
        if (cfg > nmax) return nmax;
        return cfg;
    endfunction

endpackage

// File: rtl/tbc_wr_ctrl.sv
module tbc_wr_ctrl
    import tbc_pkg::*;
#(
    parameter int BANK_BYTES = 64,
    localparam int LEN_W = $clog2(BANK_BYTES + 1),
    localparam int OFF_W = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_en,
    input  logic             wr_en,
    input  logic             set_rdy,
    input  logic             cur_busy,
    output logic             mem_we,
    output logic [OFF_W-1:0] mem_off,
    output commit_e          commit,
    output logic [LEN_W-1:0] commit_len
);
    localparam logic [LEN_W-1:0] FULL = LEN_W'(BANK_BYTES);
    localparam logic [LEN_W-1:0] LAST = LEN_W'(BANK_BYTES - 1);

    logic [LEN_W-1:0] fill;
    logic             accept;

    assign accept  = wr_en && !cur_busy && (fill < FULL);
    assign mem_we  = accept;
    assign mem_off = OFF_W'(fill);

    always_comb begin
        if (accept && auto_en && fill == LAST)
            commit = CM_AUTO;
        else if (set_rdy && !cur_busy)
            commit = CM_MANUAL;
        else
            commit = CM_NONE;
        commit_len = fill + LEN_W'(accept);
    end

    always_ff @(posedge clk) begin
        if (rst)
            fill <= '0;
        else if (commit != CM_NONE)
            fill <= '0;
        else if (accept)
            fill <= fill + 1'b1;
    end

    a_r4_no_fill_when_busy: assert property (@(posedge clk) disable iff (rst)
        cur_busy |=> (fill == $past(fill)) || (fill == '0));

    a_r5_auto_full_len: assert property (@(posedge clk) disable iff (rst)
        (commit == CM_AUTO) |-> (commit_len == FULL));

endmodule

// File: rtl/tbc_bank_ring.sv
module tbc_bank_ring
    import tbc_pkg::*;
#(
    parameter int NBANK = 3,
    parameter int BANK_BYTES = 64,
    localparam int LEN_W = $clog2(BANK_BYTES + 1),
    localparam int PTR_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int CNT_W = $clog2(NBANK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_nbanks,
    input  commit_e          commit,
    input  logic [LEN_W-1:0] commit_len,
    input  logic             ack,
    output logic             cur_busy,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             head_valid,
    output logic [LEN_W-1:0] head_len,
    output logic [CNT_W-1:0] cnt
);
    logic [NBANK-1:0] busy;
    logic [LEN_W-1:0] blen [NBANK];
    logic             do_commit, do_free;
    int unsigned      nuse;

    assign nuse       = eff_banks(int'(cfg_nbanks), NBANK);
    assign do_commit  = (commit != CM_NONE);
    assign cur_busy   = busy[wr_ptr];
    assign head_valid = busy[rd_ptr];
    assign head_len   = blen[rd_ptr];
    assign do_free    = ack && head_valid;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                busy[b] <= 1'b0;
                blen[b] <= '0;
            end else if (do_commit && wr_ptr == PTR_W'(b)) begin
                busy[b] <= 1'b1;
                blen[b] <= commit_len;
            end else if (do_free && rd_ptr == PTR_W'(b)) begin
                busy[b] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_commit) wr_ptr <= PTR_W'(ring_next(int'(wr_ptr), nuse));
            if (do_free)   rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), nuse));
            case ({do_commit, do_free})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    a_r9_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= NBANK);

    a_r8_ack_frees: assert property (@(posedge clk) disable iff (rst)
        (ack && head_valid && !do_commit) |=> (cnt == $past(cnt) - 1'b1));

    a_r8_idle_ack: assert property (@(posedge clk) disable iff (rst)
        (ack && !head_valid && !do_commit) |=> $stable(cnt));

    a_r11_no_commit_busy: assert property (@(posedge clk) disable iff (rst)
        cur_busy |-> !do_commit);

endmodule

// File: rtl/tbc_mem.sv
module tbc_mem
    import tbc_pkg::*;
#(
    parameter int NBANK = 3,
    parameter int BANK_BYTES = 64,
    localparam int PTR_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int OFF_W = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] wbank,
    input  logic [OFF_W-1:0] woff,
    input  byte_t            wdata,
    input  logic [PTR_W-1:0] rbank,
    input  logic [OFF_W-1:0] roff,
    output byte_t            rdata
);
    byte_t store [NBANK][BANK_BYTES];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (we && wbank == PTR_W'(b))
                store[b][woff] <= wdata;
        end
    end

    assign rdata = store[rbank][roff];

endmodule

// File: rtl/tbc_in_endpoint.sv
module tbc_in_endpoint
    import tbc_pkg::*;
#(
    parameter int NBANK = 3,
    parameter int BANK_BYTES = 64,
    localparam int LEN_W = $clog2(BANK_BYTES + 1),
    localparam int OFF_W = (BANK_BYTES > 1) ? $clog2(BANK_BYTES) : 1,
    localparam int PTR_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int CNT_W = $clog2(NBANK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_nbanks,
    input  logic             cfg_auto_val,
    input  logic             cpu_wr_en,
    input  logic [7:0]       cpu_wr_data,
    input  logic             cpu_set_txrdy,
    output logic             cpu_txrdy,
    output logic [CNT_W-1:0] busy_cnt,
    input  logic             irq_free_en,
    input  logic             irq_all_en,
    output logic             irq_bank_free,
    output logic             irq_all_free,
    output logic             tx_valid,
    output logic [LEN_W-1:0] tx_len,
    input  logic [OFF_W-1:0] tx_rd_addr,
    output logic [7:0]       tx_rd_data,
    input  logic             tx_ack
);
    logic             cur_busy, mem_we;
    logic [OFF_W-1:0] mem_off;
    commit_e          commit;
    logic [LEN_W-1:0] commit_len;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    tbc_wr_ctrl #(.BANK_BYTES(BANK_BYTES)) u_wr (
        .clk(clk), .rst(rst), .auto_en(cfg_auto_val), .wr_en(cpu_wr_en),
        .set_rdy(cpu_set_txrdy), .cur_busy(cur_busy), .mem_we(mem_we),
        .mem_off(mem_off), .commit(commit), .commit_len(commit_len)
    );

    tbc_bank_ring #(.NBANK(NBANK), .BANK_BYTES(BANK_BYTES)) u_ring (
        .clk(clk), .rst(rst), .cfg_nbanks(cfg_nbanks), .commit(commit),
        .commit_len(commit_len), .ack(tx_ack), .cur_busy(cur_busy),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .head_valid(tx_valid),
        .head_len(tx_len), .cnt(busy_cnt)
    );

    tbc_mem #(.NBANK(NBANK), .BANK_BYTES(BANK_BYTES)) u_mem (
        .clk(clk), .we(mem_we), .wbank(wr_ptr), .woff(mem_off),
        .wdata(cpu_wr_data), .rbank(rd_ptr), .roff(tx_rd_addr),
        .rdata(tx_rd_data)
    );

    assign cpu_txrdy     = cur_busy;
    assign irq_bank_free = irq_free_en && !cur_busy;
    assign irq_all_free  = irq_all_en && (busy_cnt == '0);

    a_r4_no_store_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !cpu_txrdy);

    a_r10_all_implies_free: assert property (@(posedge clk) disable iff (rst)
        (busy_cnt == '0) |-> !cpu_txrdy);

    a_r7_head_when_busy: assert property (@(posedge clk) disable iff (rst)
        (busy_cnt != '0) |-> tx_valid);

endmodule

// File: tb/sim_tbc_in_endpoint.sv
module sim_tbc_in_endpoint;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 3;
    localparam int BB = 4;

    logic       clk = 0, rst = 1;
    logic [1:0] cfg_nbanks = 2'd3;
    logic       cfg_auto_val = 0, cpu_wr_en = 0, cpu_set_txrdy = 0;
    logic [7:0] cpu_wr_data = 0;
    logic       irq_free_en = 1, irq_all_en = 1, tx_ack = 0;
    logic [1:0] tx_rd_addr = 0;
    logic       cpu_txrdy, irq_bank_free, irq_all_free, tx_valid;
    logic [1:0] busy_cnt;
    logic [2:0] tx_len;
    logic [7:0] tx_rd_data;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbc_in_endpoint #(.NBANK(NB), .BANK_BYTES(BB)) u0 (
        .clk(clk), .rst(rst), .cfg_nbanks(cfg_nbanks), .cfg_auto_val(cfg_auto_val),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_set_txrdy(cpu_set_txrdy),
        .cpu_txrdy(cpu_txrdy), .busy_cnt(busy_cnt), .irq_free_en(irq_free_en),
        .irq_all_en(irq_all_en), .irq_bank_free(irq_bank_free), .irq_all_free(irq_all_free),
        .tx_valid(tx_valid), .tx_len(tx_len), .tx_rd_addr(tx_rd_addr),
        .tx_rd_data(tx_rd_data), .tx_ack(tx_ack)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // op: 0 idle, 1 write byte, 2 set ready, 3 ack
    task automatic do_op(int op, logic [7:0] d);
        @(negedge clk);
        cpu_wr_en     = (op == 1);
        cpu_wr_data   = d;
        cpu_set_txrdy = (op == 2);
        tx_ack        = (op == 3);
        @(negedge clk);
        cpu_wr_en = 0; cpu_set_txrdy = 0; tx_ack = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    task automatic rd(logic [1:0] a, string req, int exp);
        tx_rd_addr = a; #1;
        chk(req, tx_rd_data, exp);
    endtask

    // {op[2], data[8], exp_cnt[2], exp_valid[1], exp_len[4], exp_rd0[8], pad[7]}
    localparam logic [31:0] VEC [7] = '{
        {2'd1, 8'h11, 2'd0, 1'b0, 4'd0, 8'h00, 7'd0},
        {2'd1, 8'h22, 2'd0, 1'b0, 4'd0, 8'h00, 7'd0},
        {2'd2, 8'h00, 2'd1, 1'b1, 4'd2, 8'h11, 7'd0},
        {2'd2, 8'h00, 2'd2, 1'b1, 4'd2, 8'h11, 7'd0},
        {2'd3, 8'h00, 2'd1, 1'b1, 4'd0, 8'h00, 7'd0},
        {2'd3, 8'h00, 2'd0, 1'b0, 4'd0, 8'h00, 7'd0},
        {2'd3, 8'h00, 2'd0, 1'b0, 4'd0, 8'h00, 7'd0}
    };

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 cnt", busy_cnt, 0);
        chk("R1 valid", tx_valid, 0);
        chk("R1 txrdy", cpu_txrdy, 0);
        chk("R1 irq_all", irq_all_free, 1);

        // Table: R2 manual packet, R3 zero-length, R8 ack incl. idle ack, R9 count
        for (int i = 0; i < 7; i++) begin
            do_op(int'(VEC[i][31:30]), VEC[i][29:22]);
            chk($sformatf("R9 vec%0d cnt", i), busy_cnt, int'(VEC[i][21:20]));
            chk($sformatf("R8 vec%0d valid", i), tx_valid, int'(VEC[i][19]));
            if (VEC[i][19]) begin
                chk($sformatf("R3 vec%0d len", i), tx_len, int'(VEC[i][18:15]));
                if (VEC[i][18:15] != 0) rd(2'd0, "R2 data", int'(VEC[i][14:7]));
            end
        end
        rd(2'd0, "R2 idle", tx_rd_data);

        // R7 order and wrap: pointers now at bank 2; fill all three
        do_op(1, 8'hA1); do_op(2, 0);
        do_op(1, 8'hB2); do_op(2, 0);
        do_op(1, 8'hC3); do_op(2, 0);
        chk("R9 full cnt", busy_cnt, 3);
        chk("R10 bank_free", irq_bank_free, 0);
        chk("R10 all_free", irq_all_free, 0);
        chk("R11 txrdy", cpu_txrdy, 1);
        do_op(2, 0);
        chk("R11 ignored set", busy_cnt, 3);
        rd(2'd0, "R7 first", 8'hA1); chk("R2 len1", tx_len, 1);
        do_op(3, 0);
        chk("R10 free after ack", irq_bank_free, 1);
        rd(2'd0, "R7 second", 8'hB2);
        do_op(3, 0);
        rd(2'd0, "R7 third", 8'hC3);
        do_op(3, 0);
        chk("R10 all after drain", irq_all_free, 1);

        // R10 enables mask
        irq_free_en = 0; irq_all_en = 0; #1;
        chk("R10 masked free", irq_bank_free, 0);
        chk("R10 masked all", irq_all_free, 0);
        irq_free_en = 1; irq_all_en = 1;

        // R5 / R6 auto validate across a boundary
        do_reset();
        cfg_auto_val = 1;
        for (int i = 1; i <= 3; i++) do_op(1, 8'(i));
        chk("R5 before last", busy_cnt, 0);
        do_op(1, 8'd4);
        chk("R5 auto cnt", busy_cnt, 1);
        chk("R5 auto len", tx_len, 4);
        rd(2'd3, "R5 last byte", 4);
        do_op(1, 8'd5); do_op(1, 8'd6);
        chk("R6 partial pending", busy_cnt, 1);
        do_op(2, 0);
        chk("R6 partial set", busy_cnt, 2);
        do_op(3, 0);
        chk("R6 partial len", tx_len, 2);
        rd(2'd1, "R5 next bank data", 6);
        do_op(3, 0);
        cfg_auto_val = 0;

        // R4 single bank: writes and set while busy ignored
        cfg_nbanks = 2'd1;
        do_reset();
        do_op(1, 8'h5A); do_op(2, 0);
        do_op(1, 8'h99);
        do_op(2, 0);
        chk("R4 cnt single", busy_cnt, 1);
        rd(2'd0, "R4 byte kept", 8'h5A);
        do_op(3, 0);
        chk("R7 single wrap free", cpu_txrdy, 0);
        do_op(2, 0);
        chk("R4 fill not moved", tx_len, 0);
        chk("R3 zlp valid", tx_valid, 1);

        // R7 cfg 0 behaves as one bank
        cfg_nbanks = 2'd0;
        do_reset();
        do_op(2, 0);
        chk("R7 cfg0 full", cpu_txrdy, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule